// File: doc/BRIEF.md
# Dual-Pulse Up/Down Presettable Counter

This block is a 4-bit counter with two count inputs: a rising edge on one steps the count up, and a rising edge on the other steps it down. A low level on the preset input loads a 4-bit data word. A high level on the clear input forces the count to zero. A mode input selects between two counting ranges. In decade mode the count runs 0 to 9. In binary mode it runs 0 to 15. In both modes the count wraps at each end of the range.

The two count inputs are asynchronous to the block. Each one passes through a two-flop synchronizer, and an edge detector then runs on the system clock. Clear and preset act on the output at once, without waiting for a clock edge. The count register captures the same value at the next system clock edge, so counting resumes from that value once clear and preset are released. Two active-low terminal flags are also produced. One flags the top of the range while the up input is low. The other flags zero while the down input is low. The counter is used as a single, stand-alone stage.

Top module: `updown_preset_counter`

## Requirements
- R1: While `clear_i` is high, `q_o` is 0 within the same cycle, with no clock edge needed. After `rst_ni` is released, `q_o` is 0.
- R2: While `load_ni` is low and `clear_i` is low, `q_o` equals `data_i` within the same cycle. After `load_ni` returns high, counting continues from that value.
- R3: When `clear_i` is high and `load_ni` is low at the same time, clear wins and `q_o` is 0.
- R4: A rising edge on `up_i` while `dn_i` is high increments the count. The new value appears on `q_o` after the third rising `clk_i` edge that follows the `up_i` edge.
- R5: A rising edge on `dn_i` while `up_i` is high decrements the count, with the same latency as R4.
- R6: With `decade_i`=1 (decade mode), counting up from 9, or from any loaded value above 9, gives 0. Counting down from 0 gives 9.
- R7: With `decade_i`=0 (binary mode), counting up from 15 gives 0 and counting down from 0 gives 15.
- R8: `carry_no` is 0 exactly when the synchronized `up_i` level is low and `q_o` equals the range top (9 in decade mode, 15 in binary mode). Otherwise it is 1.
- R9: `borrow_no` is 0 exactly when the synchronized `dn_i` level is low and `q_o` is 0. Otherwise it is 1.
- R10: Rising edges on `up_i` and `dn_i` that are synchronized in the same cycle leave the count unchanged. An `up_i` edge while `dn_i` is low leaves the count unchanged, and so does a `dn_i` edge while `up_i` is low.
- R11: Count edges that arrive while `load_ni` is low or `clear_i` is high are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clear_i | input | 1 | Active-high clear to zero, takes effect at once |
| load_ni | input | 1 | Active-low preset from data_i, takes effect at once |
| data_i | input | 4 | Preset value |
| up_i | input | 1 | Count-up pulse input, idles high |
| dn_i | input | 1 | Count-down pulse input, idles high |
| decade_i | input | 1 | 1 selects decade range (0 to 9), 0 selects binary range (0 to 15) |
| q_o | output | 4 | Count value |
| carry_no | output | 1 | Active-low terminal flag for the range top |
| borrow_no | output | 1 | Active-low terminal flag for zero |

## Verification
The count register feeds `q_o` directly whenever clear and preset are inactive. A wrong next-state value, such as a missed wrap or a step in the wrong direction, therefore shows on `q_o` in the cycle after the faulty step. That is three clock edges after the input edge that caused it. A fault in the synchronizer or in the edge arbitration shows up as a step that goes missing, is counted twice or is mistimed, and the bench checks `q_o` both one cycle before and one cycle after the expected update. The terminal flags combine the synchronized input levels with `q_o`, so a wrong flag becomes visible two edges after the input changes.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/pulse_sync_edge.sv
module pulse_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // stages reset high: inputs idle high, so no false edge after reset
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b1;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/step_arbiter.sv
module step_arbiter
  import updown_cnt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  up_lvl_i,
  input  logic  up_rise_i,
  input  logic  dn_lvl_i,
  input  logic  dn_rise_i,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_NONE;
    if (up_rise_i && dn_lvl_i && !dn_rise_i)      step_o = STEP_UP;
    else if (dn_rise_i && up_lvl_i && !up_rise_i) step_o = STEP_DN;
  end

  // R10
  same_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_rise_i && dn_rise_i) |-> step_o == STEP_NONE);
  // R10
  dn_held_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_lvl_i) |-> step_o != STEP_UP);
endmodule

// File: rtl/count_core.sv
module count_core
  import updown_cnt_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int DEC_LAST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             decade_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] DecTop = WIDTH'(DEC_LAST);
  localparam logic [WIDTH-1:0] BinTop = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  assign top_o = decade_i ? DecTop : BinTop;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (!load_ni) cnt_d = data_i;
    else begin
      unique case (step_i)
        STEP_UP: cnt_d = (cnt_q >= top_o) ? '0 : cnt_q + 1'b1;
        STEP_DN: cnt_d = (cnt_q == '0) ? top_o : cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6 R7
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_UP && !clear_i && load_ni && cnt_q >= top_o) |=> cnt_q == '0);
  // R6 R7
  dn_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_DN && !clear_i && load_ni && cnt_q == '0) |=> cnt_q == $past(top_o));
  // R4
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_UP && !clear_i && load_ni && cnt_q < top_o) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R1
  clear_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && load_ni && step_i == STEP_NONE) |=> $stable(cnt_q));
endmodule

// File: rtl/term_flags.sv
module term_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] top_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_no,
  output logic             borrow_no
);
  assign carry_no  = ~(~up_lvl_i && (q_i == top_i));
  assign borrow_no = ~(~dn_lvl_i && (q_i == '0));

  // R8
  carry_at_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (q_i == top_i && !up_lvl_i));
  // R9
  borrow_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (q_i == '0 && !dn_lvl_i));
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
  import updown_cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DEC_LAST    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             decade_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam int NumCh = 2;  // 0: up, 1: down

  logic [NumCh-1:0] raw;
  logic [NumCh-1:0] lvl;
  logic [NumCh-1:0] rise;
  step_e            step;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] top;

  assign raw = {dn_i, up_i};

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    pulse_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[c]),
      .level_o(lvl[c]),
      .rise_o (rise[c])
    );
  end

  step_arbiter u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .up_lvl_i (lvl[0]),
    .up_rise_i(rise[0]),
    .dn_lvl_i (lvl[1]),
    .dn_rise_i(rise[1]),
    .step_o   (step)
  );

  count_core #(.WIDTH(WIDTH), .DEC_LAST(DEC_LAST)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .load_ni (load_ni),
    .data_i  (data_i),
    .decade_i(decade_i),
    .step_i  (step),
    .top_o   (top),
    .cnt_o   (cnt)
  );

  // clear and preset bypass the register so they act without a clock edge
  always_comb begin
    if (clear_i)       q_o = '0;
    else if (!load_ni) q_o = data_i;
    else               q_o = cnt;
  end

  term_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .q_i      (q_o),
    .top_i    (top),
    .up_lvl_i (lvl[0]),
    .dn_lvl_i (lvl[1]),
    .carry_no (carry_no),
    .borrow_no(borrow_no)
  );

  // R2
  preset_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && !clear_i) |=> cnt == $past(data_i));
  // R3
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !load_ni) |=> cnt == '0);
endmodule

// File: tb/updown_preset_counter_tb_top.sv
module updown_preset_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       load_ni = 1'b1;
  logic [3:0] data_i = '0;
  logic       up_i = 1'b1;
  logic       dn_i = 1'b1;
  logic       decade_i = 1'b1;
  logic [3:0] q_o;
  logic       carry_no, borrow_no;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  updown_preset_counter dut_i (
    .clk_i, .rst_ni, .clear_i, .load_ni, .data_i,
    .up_i, .dn_i, .decade_i, .q_o, .carry_no, .borrow_no
  );

  // vector: {op[1:0], mode, data[3:0], exp[3:0]}; op 0 load, 1 up, 2 down
  localparam int NV = 20;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 1'b1, 4'd7,  4'd7},   // R2
    {2'd1, 1'b1, 4'd0,  4'd8},   // R4
    {2'd1, 1'b1, 4'd0,  4'd9},   // R4
    {2'd1, 1'b1, 4'd0,  4'd0},   // R6 up wrap
    {2'd2, 1'b1, 4'd0,  4'd9},   // R6 down wrap
    {2'd2, 1'b1, 4'd0,  4'd8},   // R5
    {2'd0, 1'b1, 4'd12, 4'd12},  // R2
    {2'd1, 1'b1, 4'd0,  4'd0},   // R6 above range
    {2'd0, 1'b1, 4'd12, 4'd12},
    {2'd2, 1'b1, 4'd0,  4'd11},  // R5
    {2'd0, 1'b0, 4'd14, 4'd14},
    {2'd1, 1'b0, 4'd0,  4'd15},  // R4
    {2'd1, 1'b0, 4'd0,  4'd0},   // R7 up wrap
    {2'd2, 1'b0, 4'd0,  4'd15},  // R7 down wrap
    {2'd2, 1'b0, 4'd0,  4'd14},  // R5
    {2'd0, 1'b0, 4'd3,  4'd3},
    {2'd2, 1'b0, 4'd0,  4'd2},
    {2'd1, 1'b0, 4'd0,  4'd3},
    {2'd1, 1'b0, 4'd0,  4'd4},
    {2'd2, 1'b0, 4'd0,  4'd3}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic pulse(input bit up);
    @(negedge clk_i);
    if (up) up_i = 1'b0; else dn_i = 1'b0;
    repeat (4) @(negedge clk_i);
    if (up) up_i = 1'b1; else dn_i = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic load(input logic [3:0] d);
    @(negedge clk_i);
    data_i = d;
    load_ni = 1'b0;
    @(negedge clk_i);
    load_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset q", q_o, 4'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 q after reset", q_o, 4'd0);
    check("R8 carry idle", {3'b0, carry_no}, 4'd1);
    check("R9 borrow idle", {3'b0, borrow_no}, 4'd1);

    for (int i = 0; i < NV; i++) begin
      decade_i = VEC[i][8];
      case (VEC[i][10:9])
        2'd0: load(VEC[i][7:4]);
        2'd1: pulse(1'b1);
        default: pulse(1'b0);
      endcase
      check($sformatf("R2/R4/R5/R6/R7 vector %0d", i), q_o, VEC[i][3:0]);
    end

    // R4 latency: unchanged after two edges, updated after the third
    decade_i = 1'b1;
    load(4'd2);
    up_i = 1'b0;
    repeat (4) @(negedge clk_i);
    up_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R4 not yet", q_o, 4'd2);
    @(negedge clk_i);
    check("R4 third edge", q_o, 4'd3);
    repeat (2) @(negedge clk_i);

    // R2 immediate preset
    @(negedge clk_i);
    data_i = 4'd6;
    load_ni = 1'b0;
    #1 check("R2 immediate", q_o, 4'd6);
    data_i = 4'd5;
    #0.5 check("R2 follows data", q_o, 4'd5);
    // R11 edge during preset is lost
    @(negedge clk_i);
    up_i = 1'b0;
    repeat (4) @(negedge clk_i);
    up_i = 1'b1;
    repeat (4) @(negedge clk_i);
    load_ni = 1'b1;
    @(negedge clk_i);
    check("R11 edge during preset", q_o, 4'd5);

    // R1 immediate clear, R3 priority
    clear_i = 1'b1;
    #1 check("R1 immediate clear", q_o, 4'd0);
    load_ni = 1'b0;
    data_i = 4'd9;
    #0.5 check("R3 clear over preset", q_o, 4'd0);
    @(negedge clk_i);
    load_ni = 1'b1;
    dn_i = 1'b0;
    repeat (4) @(negedge clk_i);
    dn_i = 1'b1;
    repeat (4) @(negedge clk_i);
    clear_i = 1'b0;
    @(negedge clk_i);
    check("R11 edge during clear", q_o, 4'd0);
    check("R3 register cleared", q_o, 4'd0);

    // R8 carry
    load(4'd9);
    up_i = 1'b0;
    #1 check("R8 carry waits for sync", {3'b0, carry_no}, 4'd1);
    repeat (3) @(negedge clk_i);
    check("R8 carry low at 9", {3'b0, carry_no}, 4'd0);
    check("R9 borrow high at 9", {3'b0, borrow_no}, 4'd1);
    decade_i = 1'b0;
    #1 check("R8 carry high at 9 binary", {3'b0, carry_no}, 4'd1);
    decade_i = 1'b1;
    up_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R6 wrap after carry", q_o, 4'd0);
    check("R8 carry released", {3'b0, carry_no}, 4'd1);

    // R9 borrow
    dn_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 borrow low at 0", {3'b0, borrow_no}, 4'd0);
    dn_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 borrow released", {3'b0, borrow_no}, 4'd1);
    check("R6 down wrap", q_o, 4'd9);

    // R10 simultaneous edges
    decade_i = 1'b0;
    load(4'd8);
    up_i = 1'b0;
    dn_i = 1'b0;
    repeat (4) @(negedge clk_i);
    up_i = 1'b1;
    dn_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10 simultaneous", q_o, 4'd8);

    // R10 up edge while down held low
    dn_i = 1'b0;
    up_i = 1'b0;
    repeat (4) @(negedge clk_i);
    up_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R10 up with down low", q_o, 4'd8);
    dn_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R5 down release counts", q_o, 4'd7);

    // R1 async reset mid-count
    rst_ni = 1'b0;
    #1 check("R1 reset clears", q_o, 4'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 holds after reset", q_o, 4'd0);

    finish_run();
  end
endmodule